// File: doc/BRIEF.md
# DMA Channel Control/Status Register

This block keeps the 16-bit control/status word of one DMA channel, plus three selector registers that the channel sequencer uses to decide when to interrupt, branch or wait. The upper byte of the word holds run-state flags. The lower byte holds device-dependent status bits.

Software reaches the block through a simple register port. Every write carries a per-bit modify mask, so only the bits selected by the mask take the supplied value. The sequencer reports three things: that it is active, that it has died, and that a branch was taken. The attached device writes its status bits through a per-bit update port of its own. When a device update and a software write touch the same status bit in the same cycle, the device update wins.

The block drives the run, pause, flush and wake requests to the sequencer. It also drives the full status word, which the sequencer writes back into descriptors. Three condition flags come out as well; each compares the device status with one selector.

Top module: `dmac_chan_csr`

## Requirements
- R1: After a synchronous active-low reset, the status word and all three selector registers read as zero.
- R2: The status word has this layout: bit 15 run, bit 14 pause, bit 13 flush, bit 12 wake, bit 11 dead, bit 10 active, bit 9 always reads 0, bit 8 branch-taken, bits 7..0 device status. Register address 0 selects the status word for both read and write. The read port is combinational from the stored state.
- R3: A software write to address 0 changes only the bits whose mask bit is 1; each such bit takes the matching data bit on the next clock edge. This holds for run, pause, branch-taken and the device bits. For example, mask 0x0003 with data 0 clears bits 1..0 and leaves every other bit unchanged.
- R4: Flush and wake are 1 for exactly the one cycle after a write whose mask and data both have that bit set. In every other cycle they read 0.
- R5: Dead (bit 11) ignores software writes. It becomes 1 the cycle after `seq_dead_set` is high. It stays 1 while run reads 1. It returns to 0 the cycle after run reads 0, unless a new set arrives in that cycle.
- R6: Active (bit 10) ignores software writes. In each cycle it equals run AND `seq_active` as they were in the previous cycle.
- R7: `seq_branch_taken` sets bit 8 on the next edge, and it overrides a same-cycle software write that clears bit 8. Software can clear bit 8 when no set is pending.
- R8: For each bit i with `dev_upd_mask[i]`=1, status bit i takes `dev_upd_val[i]` on the next edge, whatever a same-cycle software write asks for.
- R9: Addresses 1, 2 and 3 hold the interrupt, branch and wait selectors. In each selector, bits 15..8 are a match mask and bits 7..0 a match value. Writes to a selector use the same per-bit mask rule as R3.
- R10: Each condition output is 1 exactly when (device status AND selector mask) equals the selector value. It is combinational from the current register contents: `cond_int_o` uses address 1, `cond_branch_o` address 2 and `cond_wait_o` address 3.
- R11: `run_req_o`, `pause_req_o`, `flush_req_o` and `wake_req_o` always equal status bits 15, 14, 13 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sw_wr_en | input | 1 | Software write strobe |
| sw_wr_addr | input | 2 | Write address (0 status, 1 interrupt sel, 2 branch sel, 3 wait sel) |
| sw_wr_mask | input | 16 | Per-bit modify mask |
| sw_wr_data | input | 16 | New bit values |
| sw_rd_addr | input | 2 | Read address, same map |
| sw_rd_data | output | 16 | Read data |
| dev_upd_mask | input | 8 | Device status bits to update |
| dev_upd_val | input | 8 | Device status new values |
| seq_branch_taken | input | 1 | Sequencer took a branch |
| seq_active | input | 1 | Sequencer is executing |
| seq_dead_set | input | 1 | Sequencer hit a fatal condition |
| chan_status_o | output | 16 | Full status word |
| run_req_o | output | 1 | Run request |
| pause_req_o | output | 1 | Pause request |
| flush_req_o | output | 1 | One-cycle flush request |
| wake_req_o | output | 1 | One-cycle wake request |
| cond_int_o | output | 1 | Interrupt selector matches |
| cond_branch_o | output | 1 | Branch selector matches |
| cond_wait_o | output | 1 | Wait selector matches |

## Verification
Every stored bit reaches a port within one clock: the status word appears on `chan_status_o` directly, and each selector appears through the read port and through its condition flag. A wrong merge of device and software updates therefore shows as a wrong low byte in the very next cycle. A stuck pulse bit shows as a request that outlives its single cycle. A dead or active flag that ignores run shows one edge after run changes. The bench compares every output against a cycle model on every cycle, so a corrupted bit is caught at the first cycle in which it differs.

// File: rtl/dmac_pkg.sv
// Package: shared constants and the register address map for the DMA
// channel control/status block. Assumes a 2-bit register address space.
package dmac_pkg;

    typedef enum logic [1:0] {
        ADDR_STATUS  = 2'd0,
        ADDR_SEL_INT = 2'd1,
        ADDR_SEL_BR  = 2'd2,
        ADDR_SEL_WT  = 2'd3
    } csr_addr_e;

    // Flag positions inside the run-state byte (offset from its bit 0)
    localparam int RS_BRANCH = 0;
    localparam int RS_RSVD   = 1;
    localparam int RS_ACTIVE = 2;
    localparam int RS_DEAD   = 3;
    localparam int RS_WAKE   = 4;
    localparam int RS_FLUSH  = 5;
    localparam int RS_PAUSE  = 6;
    localparam int RS_RUN    = 7;

    localparam int NUM_SEL   = 3;

endpackage

// File: rtl/dmac_runstate.sv
// Module: run-state byte of the channel status word.
// Holds run, pause, flush, wake, dead, active and branch-taken flags.
// Assumes RS_W >= 8; flags sit at fixed offsets from the package.
module dmac_runstate
    import dmac_pkg::*;
#(
    parameter int RS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_hit,
    input  logic [RS_W-1:0] wr_mask,
    input  logic [RS_W-1:0] wr_data,
    input  logic            seq_active,
    input  logic            seq_dead_set,
    input  logic            branch_taken,
    output logic [RS_W-1:0] rs_q
);

    logic [RS_W-1:0] rs_d;
    logic [RS_W-1:0] sw_sel;

    // Per-bit software write enable
    assign sw_sel = wr_hit ? wr_mask : '0;

    // Next-state for every run-state flag
    always_comb begin
        rs_d = '0;
        rs_d[RS_RUN]    = sw_sel[RS_RUN]   ? wr_data[RS_RUN]   : rs_q[RS_RUN];
        rs_d[RS_PAUSE]  = sw_sel[RS_PAUSE] ? wr_data[RS_PAUSE] : rs_q[RS_PAUSE];
        rs_d[RS_FLUSH]  = sw_sel[RS_FLUSH] & wr_data[RS_FLUSH];
        rs_d[RS_WAKE]   = sw_sel[RS_WAKE]  & wr_data[RS_WAKE];
        rs_d[RS_DEAD]   = seq_dead_set | (rs_q[RS_DEAD] & rs_q[RS_RUN]);
        rs_d[RS_ACTIVE] = rs_q[RS_RUN] & seq_active;
        rs_d[RS_RSVD]   = 1'b0;
        rs_d[RS_BRANCH] = branch_taken |
                          (sw_sel[RS_BRANCH] ? wr_data[RS_BRANCH] : rs_q[RS_BRANCH]);
    end

    // Run-state storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

endmodule

// File: rtl/dmac_devstat.sv
// Module: device-dependent status byte. Software and the device both
// update it per bit; the device update wins on a same-cycle collision.
module dmac_devstat #(
    parameter int DEV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_hit,
    input  logic [DEV_W-1:0] wr_mask,
    input  logic [DEV_W-1:0] wr_data,
    input  logic [DEV_W-1:0] hw_mask,
    input  logic [DEV_W-1:0] hw_val,
    output logic [DEV_W-1:0] dev_q
);

    logic [DEV_W-1:0] dev_d;

    // Per-bit merge: device first, then software, else hold
    always_comb begin
        for (int i = 0; i < DEV_W; i++) begin
            if (hw_mask[i])                dev_d[i] = hw_val[i];
            else if (wr_hit && wr_mask[i]) dev_d[i] = wr_data[i];
            else                           dev_d[i] = dev_q[i];
        end
    end

    // Device status storage with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) dev_q <= '0;
        else        dev_q <= dev_d;
    end

endmodule

// File: rtl/dmac_selbank.sv
// Module: bank of selector registers, each a match mask (upper half) and a
// match value (lower half), with one condition flag per selector.
// Assumes selector k is written when wr_en is high and wr_idx equals k.
module dmac_selbank #(
    parameter int DEV_W   = 8,
    parameter int NUM_SEL = 3,
    parameter int IDX_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [2*DEV_W-1:0]                wr_mask,
    input  logic [2*DEV_W-1:0]                wr_data,
    input  logic [DEV_W-1:0]                  dev_i,
    output logic [NUM_SEL-1:0][2*DEV_W-1:0]   sel_o,
    output logic [NUM_SEL-1:0]                cond_o
);

    localparam int SEL_W = 2 * DEV_W;

    for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
        logic             hit;
        logic [SEL_W-1:0] sel_q;

        assign hit = wr_en && (wr_idx == IDX_W'(g));

        // Selector storage with masked write and synchronous reset
        always_ff @(posedge clk) begin
            if (!rst_n)   sel_q <= '0;
            else if (hit) sel_q <= (sel_q & ~wr_mask) | (wr_data & wr_mask);
        end

        assign sel_o[g]  = sel_q;
        // Match flag: masked device status against the stored value
        assign cond_o[g] = ((dev_i & sel_q[SEL_W-1:DEV_W]) == sel_q[DEV_W-1:0]);
    end

endmodule

// File: rtl/dmac_chan_csr.sv
// Module: top of the DMA channel control/status register block.
// Decodes the register port, joins the run-state and device bytes into the
// status word, and exposes requests and selector match flags.
// Assumes address 0 is the status word and 1..3 are the selectors.
module dmac_chan_csr
    import dmac_pkg::*;
#(
    parameter int DEV_W = 8,
    localparam int CSR_W = 2 * DEV_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_wr_en,
    input  logic [1:0]       sw_wr_addr,
    input  logic [CSR_W-1:0] sw_wr_mask,
    input  logic [CSR_W-1:0] sw_wr_data,
    input  logic [1:0]       sw_rd_addr,
    output logic [CSR_W-1:0] sw_rd_data,
    input  logic [DEV_W-1:0] dev_upd_mask,
    input  logic [DEV_W-1:0] dev_upd_val,
    input  logic             seq_branch_taken,
    input  logic             seq_active,
    input  logic             seq_dead_set,
    output logic [CSR_W-1:0] chan_status_o,
    output logic             run_req_o,
    output logic             pause_req_o,
    output logic             flush_req_o,
    output logic             wake_req_o,
    output logic             cond_int_o,
    output logic             cond_branch_o,
    output logic             cond_wait_o
);

    localparam int IDX_W = 2;

    logic                             st_hit;
    logic                             sel_wr;
    logic [IDX_W-1:0]                 sel_idx;
    logic [IDX_W-1:0]                 rd_idx;
    logic [DEV_W-1:0]                 rs_q;
    logic [DEV_W-1:0]                 dev_q;
    logic [NUM_SEL-1:0][CSR_W-1:0]    sel_all;
    logic [NUM_SEL-1:0]               cond_all;

    // Write decode: status word versus selector bank
    assign st_hit  = sw_wr_en && (csr_addr_e'(sw_wr_addr) == ADDR_STATUS);
    assign sel_wr  = sw_wr_en && (csr_addr_e'(sw_wr_addr) != ADDR_STATUS);
    assign sel_idx = sw_wr_addr - IDX_W'(1);
    assign rd_idx  = sw_rd_addr - IDX_W'(1);

    dmac_runstate #(.RS_W(DEV_W)) runstate_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (st_hit),
        .wr_mask      (sw_wr_mask[CSR_W-1:DEV_W]),
        .wr_data      (sw_wr_data[CSR_W-1:DEV_W]),
        .seq_active   (seq_active),
        .seq_dead_set (seq_dead_set),
        .branch_taken (seq_branch_taken),
        .rs_q         (rs_q)
    );

    dmac_devstat #(.DEV_W(DEV_W)) devstat_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (st_hit),
        .wr_mask (sw_wr_mask[DEV_W-1:0]),
        .wr_data (sw_wr_data[DEV_W-1:0]),
        .hw_mask (dev_upd_mask),
        .hw_val  (dev_upd_val),
        .dev_q   (dev_q)
    );

    dmac_selbank #(.DEV_W(DEV_W), .NUM_SEL(NUM_SEL), .IDX_W(IDX_W)) selbank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (sel_wr),
        .wr_idx  (sel_idx),
        .wr_mask (sw_wr_mask),
        .wr_data (sw_wr_data),
        .dev_i   (dev_q),
        .sel_o   (sel_all),
        .cond_o  (cond_all)
    );

    // Assemble the status word and the sequencer-facing outputs
    assign chan_status_o = {rs_q, dev_q};
    assign run_req_o     = rs_q[RS_RUN];
    assign pause_req_o   = rs_q[RS_PAUSE];
    assign flush_req_o   = rs_q[RS_FLUSH];
    assign wake_req_o    = rs_q[RS_WAKE];
    assign cond_int_o    = cond_all[0];
    assign cond_branch_o = cond_all[1];
    assign cond_wait_o   = cond_all[2];

    // Read mux across status word and selectors
    always_comb begin
        if (csr_addr_e'(sw_rd_addr) == ADDR_STATUS) sw_rd_data = chan_status_o;
        else                                        sw_rd_data = sel_all[rd_idx];
    end

endmodule

// File: rtl/dmac_chan_csr_chk.sv
// Module: property checker for dmac_chan_csr, attached by bind.
// Observes only the top-level ports.
module dmac_chan_csr_chk #(
    parameter int DEV_W = 8,
    localparam int CSR_W = 2 * DEV_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sw_wr_en,
    input logic [1:0]       sw_wr_addr,
    input logic [CSR_W-1:0] sw_wr_mask,
    input logic [CSR_W-1:0] sw_wr_data,
    input logic [DEV_W-1:0] dev_upd_mask,
    input logic [DEV_W-1:0] dev_upd_val,
    input logic             seq_branch_taken,
    input logic             seq_active,
    input logic             seq_dead_set,
    input logic [CSR_W-1:0] chan_status_o,
    input logic             run_req_o,
    input logic             flush_req_o
);

    localparam int B_FLUSH  = CSR_W - 3;
    localparam int B_DEAD   = CSR_W - 5;
    localparam int B_ACTIVE = CSR_W - 6;
    localparam int B_BRANCH = DEV_W;

    logic st_wr;
    assign st_wr = sw_wr_en && (sw_wr_addr == 2'd0);

    p_flush_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req_o |-> $past(st_wr && sw_wr_mask[B_FLUSH] && sw_wr_data[B_FLUSH]));

    p_dead_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_req_o && !seq_dead_set) |=> !chan_status_o[B_DEAD]);

    p_active_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_status_o[B_ACTIVE] |-> $past(seq_active && run_req_o));

    p_branch_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        seq_branch_taken |=> chan_status_o[B_BRANCH]);

    p_dev_prio_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_upd_mask != '0) |=>
        ((chan_status_o[DEV_W-1:0] & $past(dev_upd_mask)) ==
         ($past(dev_upd_val) & $past(dev_upd_mask))));

    p_mask_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && dev_upd_mask == '0) |=>
        ((chan_status_o[DEV_W-1:0] & ~$past(sw_wr_mask[DEV_W-1:0])) ==
         ($past(chan_status_o[DEV_W-1:0]) & ~$past(sw_wr_mask[DEV_W-1:0]))));

endmodule

bind dmac_chan_csr dmac_chan_csr_chk #(.DEV_W(DEV_W)) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .sw_wr_en         (sw_wr_en),
    .sw_wr_addr       (sw_wr_addr),
    .sw_wr_mask       (sw_wr_mask),
    .sw_wr_data       (sw_wr_data),
    .dev_upd_mask     (dev_upd_mask),
    .dev_upd_val      (dev_upd_val),
    .seq_branch_taken (seq_branch_taken),
    .seq_active       (seq_active),
    .seq_dead_set     (seq_dead_set),
    .chan_status_o    (chan_status_o),
    .run_req_o        (run_req_o),
    .flush_req_o      (flush_req_o)
);

// File: tb/dmac_chan_csr_tb.sv
// Bench: directed corners plus seeded random traffic, all compared against
// a cycle model written from the requirements.
module dmac_chan_csr_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        sw_wr_en;
    logic [1:0]  sw_wr_addr;
    logic [15:0] sw_wr_mask;
    logic [15:0] sw_wr_data;
    logic [1:0]  sw_rd_addr;
    logic [15:0] sw_rd_data;
    logic [7:0]  dev_upd_mask;
    logic [7:0]  dev_upd_val;
    logic        seq_branch_taken;
    logic        seq_active;
    logic        seq_dead_set;
    logic [15:0] chan_status_o;
    logic        run_req_o, pause_req_o, flush_req_o, wake_req_o;
    logic        cond_int_o, cond_branch_o, cond_wait_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [15:0] m_st;
    logic [15:0] m_sel [1:3];

    always #10 clk = ~clk;

    dmac_chan_csr dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .sw_wr_en         (sw_wr_en),
        .sw_wr_addr       (sw_wr_addr),
        .sw_wr_mask       (sw_wr_mask),
        .sw_wr_data       (sw_wr_data),
        .sw_rd_addr       (sw_rd_addr),
        .sw_rd_data       (sw_rd_data),
        .dev_upd_mask     (dev_upd_mask),
        .dev_upd_val      (dev_upd_val),
        .seq_branch_taken (seq_branch_taken),
        .seq_active       (seq_active),
        .seq_dead_set     (seq_dead_set),
        .chan_status_o    (chan_status_o),
        .run_req_o        (run_req_o),
        .pause_req_o      (pause_req_o),
        .flush_req_o      (flush_req_o),
        .wake_req_o       (wake_req_o),
        .cond_int_o       (cond_int_o),
        .cond_branch_o    (cond_branch_o),
        .cond_wait_o      (cond_wait_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic match(input logic [15:0] sel, input logic [7:0] dev);
        return ((dev & sel[15:8]) == sel[7:0]);
    endfunction

    // Compare every output against the model state
    task automatic check_all();
        logic [15:0] exp_rd;
        exp_rd = (sw_rd_addr == 2'd0) ? m_st : m_sel[sw_rd_addr];
        chk(chan_status_o[15:14] === m_st[15:14], "R3 run/pause", chan_status_o, m_st);
        chk(chan_status_o[13:12] === m_st[13:12], "R4 flush/wake", chan_status_o, m_st);
        chk(chan_status_o[11] === m_st[11], "R5 dead", chan_status_o, m_st);
        chk(chan_status_o[10] === m_st[10], "R6 active", chan_status_o, m_st);
        chk(chan_status_o[9] === 1'b0, "R2 reserved bit", chan_status_o, m_st);
        chk(chan_status_o[8] === m_st[8], "R7 branch flag", chan_status_o, m_st);
        chk(chan_status_o[7:0] === m_st[7:0], "R8 device status", chan_status_o, m_st);
        chk(sw_rd_data === exp_rd, (sw_rd_addr == 2'd0) ? "R2 read status" : "R9 read selector",
            sw_rd_data, exp_rd);
        chk({cond_int_o, cond_branch_o, cond_wait_o} ===
            {match(m_sel[1], m_st[7:0]), match(m_sel[2], m_st[7:0]), match(m_sel[3], m_st[7:0])},
            "R10 conditions", {13'd0, cond_int_o, cond_branch_o, cond_wait_o},
            {13'd0, match(m_sel[1], m_st[7:0]), match(m_sel[2], m_st[7:0]),
             match(m_sel[3], m_st[7:0])});
        chk({run_req_o, pause_req_o, flush_req_o, wake_req_o} === m_st[15:12],
            "R11 requests", {12'd0, run_req_o, pause_req_o, flush_req_o, wake_req_o},
            {12'd0, m_st[15:12]});
    endtask

    // One clock: drive inputs, check, advance the model with the edge
    task automatic step(input logic rst, input logic we, input logic [1:0] wa,
                        input logic [15:0] wm, input logic [15:0] wd,
                        input logic [1:0] ra, input logic [7:0] hm, input logic [7:0] hv,
                        input logic bt, input logic act, input logic dd);
        logic [15:0] n;
        logic        wc;
        rst_n = rst; sw_wr_en = we; sw_wr_addr = wa; sw_wr_mask = wm; sw_wr_data = wd;
        sw_rd_addr = ra; dev_upd_mask = hm; dev_upd_val = hv;
        seq_branch_taken = bt; seq_active = act; seq_dead_set = dd;
        #1;
        if (rst) check_all();
        wc = we && (wa == 2'd0);
        n  = '0;
        n[15] = (wc && wm[15]) ? wd[15] : m_st[15];
        n[14] = (wc && wm[14]) ? wd[14] : m_st[14];
        n[13] = wc && wm[13] && wd[13];
        n[12] = wc && wm[12] && wd[12];
        n[11] = dd || (m_st[11] && m_st[15]);
        n[10] = m_st[15] && act;
        n[8]  = bt || ((wc && wm[8]) ? wd[8] : m_st[8]);
        for (int i = 0; i < 8; i++)
            n[i] = hm[i] ? hv[i] : ((wc && wm[i]) ? wd[i] : m_st[i]);
        @(posedge clk);
        if (!rst) begin
            m_st = '0;
            for (int k = 1; k <= 3; k++) m_sel[k] = '0;
        end else begin
            m_st = n;
            if (we && wa != 2'd0) m_sel[wa] = (m_sel[wa] & ~wm) | (wd & wm);
        end
        @(negedge clk);
    endtask

    task automatic idle(input logic [1:0] ra, input logic act);
        step(1'b1, 1'b0, 2'd0, 16'h0, 16'h0, ra, 8'h0, 8'h0, 1'b0, act, 1'b0);
    endtask

    task automatic wr(input logic [1:0] wa, input logic [15:0] wm, input logic [15:0] wd);
        step(1'b1, 1'b1, wa, wm, wd, 2'd0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_st = '0;
        for (int k = 1; k <= 3; k++) m_sel[k] = '0;
        @(negedge clk);
        repeat (3) step(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0);

        // R1: every register reads zero after reset
        for (int a = 0; a < 4; a++) begin
            sw_rd_addr = 2'(a); #1;
            chk(sw_rd_data === 16'h0, "R1 reset value", sw_rd_data, 16'h0);
        end
        chk(chan_status_o === 16'h0, "R1 reset status", chan_status_o, 16'h0);

        // R3: fill device byte, then mask 0x0003 with data 0 clears bits 1..0 only
        wr(2'd0, 16'h00FF, 16'h00FF);
        wr(2'd0, 16'h0003, 16'h0000);
        idle(2'd0, 1'b0);
        chk(chan_status_o[7:0] === 8'hFC, "R3 mask example", chan_status_o, 16'h00FC);

        // R8: device and software collide on bit 2; device value wins
        step(1'b1, 1'b1, 2'd0, 16'h0004, 16'h0000, 2'd0, 8'h04, 8'h04, 1'b0, 1'b0, 1'b0);
        idle(2'd0, 1'b0);

        // R4: back-to-back flush writes, then one wake pulse
        wr(2'd0, 16'h2000, 16'h2000);
        wr(2'd0, 16'h2000, 16'h2000);
        wr(2'd0, 16'h1000, 16'h1000);
        idle(2'd0, 1'b0);
        idle(2'd0, 1'b0);

        // R5/R6: run, go active, die, then clear run
        wr(2'd0, 16'h8000, 16'h8000);
        idle(2'd0, 1'b1);
        step(1'b1, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 8'h0, 8'h0, 1'b0, 1'b1, 1'b1);
        wr(2'd0, 16'h0C00, 16'h0000);   // software tries to clear dead/active: ignored
        idle(2'd0, 1'b1);
        wr(2'd0, 16'h8000, 16'h0000);
        idle(2'd0, 1'b1);
        idle(2'd0, 1'b1);

        // R7: branch set beats a same-cycle software clear, then software clears it
        step(1'b1, 1'b1, 2'd0, 16'h0100, 16'h0000, 2'd0, 8'h0, 8'h0, 1'b1, 1'b0, 1'b0);
        wr(2'd0, 16'h0100, 16'h0000);
        idle(2'd0, 1'b0);

        // R9/R10: program selectors, then walk device status through a match
        wr(2'd1, 16'hFFFF, 16'h0301);
        wr(2'd2, 16'hFF00, 16'h0000);
        wr(2'd3, 16'h00FF, 16'h00AA);
        idle(2'd1, 1'b0);
        wr(2'd0, 16'h00FF, 16'h0001);
        idle(2'd2, 1'b0);
        idle(2'd3, 1'b0);

        // Mid-run reset returns everything to zero (R1)
        step(1'b0, 1'b0, 2'd0, 16'h0, 16'h0, 2'd0, 8'h0, 8'h0, 1'b0, 1'b0, 1'b0);
        idle(2'd1, 1'b0);

        // Seeded random traffic with small masks so conditions toggle
        for (int c = 0; c < 3000; c++) begin
            logic        we, bt, act, dd;
            logic [1:0]  wa, ra;
            logic [15:0] wm, wd;
            logic [7:0]  hm, hv;
            we  = ($urandom % 2) == 0;
            wa  = ($urandom % 3 == 0) ? 2'($urandom) : 2'd0;
            wm  = 16'($urandom);
            if ($urandom % 2 == 0) wm = wm & 16'h3F0F;
            wd  = 16'($urandom);
            ra  = 2'($urandom);
            hm  = ($urandom % 4 == 0) ? 8'($urandom) : 8'h0;
            hv  = 8'($urandom);
            bt  = ($urandom % 10) == 0;
            act = ($urandom % 10) < 7;
            dd  = ($urandom % 20) == 0;
            step(($urandom % 400) != 0, we, wa, wm, wd, ra, hm, hv, bt, act, dd);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule